// File: doc/BRIEF.md
# Secondary Bus Park and Width-Signal Controller

This block controls the secondary-side bus drivers of a PCI/PCI-X bridge when the bridge is not running a transaction. The block samples its own grant, its own request and the two bus-activity strobes on each clock. It parks the address/data, command/byte-enable and parity lines when the bus is idle, the grant is held and no request is pending. While the secondary bus reset is active it holds those same lines at zero. Choosing which agent parks is left to the arbiter. This block only acts on its own grant.

It also asserts the 64-bit request strobe when the secondary reset starts and holds it for a minimum number of clocks. Devices on the bus use that window to learn whether they sit on a 64-bit or a 32-bit bus. If the reset lasts longer than the minimum, the strobe stays asserted until the reset ends. Parity trails the lines it covers by one clock, as the bus protocol requires.

Top module: `pci_park_ctrl`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it rises, every enable, value and `req64_o` output is 0.
- R2: When an edge samples `gnt_i`=1, `req_i`=0, `frame_ni`=1, `irdy_ni`=1 and `bus_rst_i`=0, then from that edge `ad_cbe_oe_o`=1, `ad_o`=`PARK_AD` and `cbe_o`=`PARK_CBE`.
- R3: When an edge samples `bus_rst_i`=0 and any of these holds: grant low, request high, `frame_ni` low or `irdy_ni` low, then from that edge `ad_cbe_oe_o`=0 and `ad_o`/`cbe_o` read 0. Drivers therefore leave the bus one clock after the grant is removed.
- R4: When an edge samples `bus_rst_i`=1, then from that edge `ad_cbe_oe_o`=1 with `ad_o` and `cbe_o` all zero, whatever the grant. At the same edge `par_o` is set to 0.
- R5: At an edge that samples `bus_rst_i`=0, `par_oe_o` takes the value `ad_cbe_oe_o` had in the preceding cycle. `par_o` takes the XOR of all bits of `ad_o` and `cbe_o` from the preceding cycle, which gives even parity across the three groups.
- R6: `req64_o` (1 = REQ64# driven low) is 1 from the first edge that samples `bus_rst_i`=1 after a sample of 0, or after `rst_ni` release.
- R7: Once raised, `req64_o` drops at the first edge k≥`REQ64_HOLD` after the window start that samples `bus_rst_i`=0. It is therefore asserted for max(`REQ64_HOLD`, reset length in cycles) cycles.
- R8: A new rising sample of `bus_rst_i` during an open window restarts the `REQ64_HOLD` count from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| bus_rst_i | input | 1 | Secondary bus reset active, sampled |
| gnt_i | input | 1 | Grant to this agent |
| req_i | input | 1 | Request from this agent |
| frame_ni | input | 1 | Sampled FRAME#, active low |
| irdy_ni | input | 1 | Sampled IRDY#, active low |
| ad_o | output | AD_W | Address/data drive value |
| cbe_o | output | CBE_W | Command/byte-enable drive value |
| ad_cbe_oe_o | output | 1 | Output enable for ad_o and cbe_o |
| par_o | output | 1 | Parity drive value |
| par_oe_o | output | 1 | Output enable for par_o |
| req64_o | output | 1 | 1 drives REQ64# asserted (low) |

## Verification
The bench builds the block with `REQ64_HOLD`=10, `PARK_AD`=32'h1234_5A5A and `PARK_CBE`=4'h3. With nonzero park values, a park cycle can be told apart from a reset-zero cycle. The parity bit then also depends on real data and does not sit at 0. A hold of 10 lets short pulses, long resets and a pulse re-raised inside an open window each end at a different, predictable release edge.

// File: rtl/pci_park_pkg.sv
package pci_park_pkg;
  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_ZERO = 2'd1,
    DRV_PARK = 2'd2
  } drv_mode_e;
endpackage

// File: rtl/park_decider.sv
module park_decider
  import pci_park_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bus_rst_i,
  input  logic      gnt_i,
  input  logic      req_i,
  input  logic      frame_ni,
  input  logic      irdy_ni,
  output drv_mode_e mode_o
);
  drv_mode_e mode_q;
  logic      idle;

  assign idle = frame_ni & irdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     mode_q <= DRV_OFF;
    else if (bus_rst_i)              mode_q <= DRV_ZERO;
    else if (gnt_i && !req_i && idle) mode_q <= DRV_PARK;
    else                             mode_q <= DRV_OFF;
  end

  assign mode_o = mode_q;

  a_r2_park_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && !req_i && frame_ni && irdy_ni && !bus_rst_i) |=> (mode_o == DRV_PARK));
  a_r3_grant_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_i && !bus_rst_i) |=> (mode_o == DRV_OFF));
  a_r3_busy_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(frame_ni && irdy_ni) && !bus_rst_i) |=> (mode_o != DRV_PARK));
endmodule

// File: rtl/bus_drv.sv
module bus_drv
  import pci_park_pkg::*;
#(
  parameter int unsigned           AD_W     = 32,
  parameter int unsigned           CBE_W    = 4,
  parameter logic [AD_W-1:0]       PARK_AD  = '0,
  parameter logic [CBE_W-1:0]      PARK_CBE = '0
) (
  input  drv_mode_e        mode_i,
  output logic             oe_o,
  output logic [AD_W-1:0]  ad_o,
  output logic [CBE_W-1:0] cbe_o
);
  logic park;
  assign park = (mode_i == DRV_PARK);
  assign oe_o = (mode_i != DRV_OFF);

  for (genvar i = 0; i < AD_W; i++) begin : g_ad
    assign ad_o[i] = park & PARK_AD[i];
  end
  for (genvar j = 0; j < CBE_W; j++) begin : g_cbe
    assign cbe_o[j] = park & PARK_CBE[j];
  end
endmodule

// File: rtl/par_gen.sv
module par_gen #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rst_i,
  input  logic             oe_i,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  output logic             par_o,
  output logic             par_oe_o
);
  logic par_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= bus_rst_i ? 1'b0 : ^{ad_i, cbe_i};
      oe_q  <= oe_i;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;
endmodule

// File: rtl/req64_timer.sv
module req64_timer #(
  parameter int unsigned HOLD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_rst_i,
  output logic req64_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          rst_d_q, req_q, start, done;

  assign start = bus_rst_i & ~rst_d_q;
  assign done  = (cnt_q >= CW'(HOLD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_d_q <= 1'b0;
      req_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      rst_d_q <= bus_rst_i;
      if (start) begin
        req_q <= 1'b1;
        cnt_q <= '0;
      end else if (req_q) begin
        if (cnt_q != CW'(HOLD)) cnt_q <= cnt_q + 1'b1;
        if (!bus_rst_i && done) req_q <= 1'b0;
      end
    end
  end

  assign req64_o = req_q;

  a_r6_window_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> req64_o);
  a_r7_no_drop_in_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req64_o) |-> !$past(bus_rst_i));
  a_r8_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_i && !rst_d_q) |=> (req64_o && cnt_q == '0));
endmodule

// File: rtl/pci_park_ctrl.sv
module pci_park_ctrl
  import pci_park_pkg::*;
#(
  parameter int unsigned      AD_W       = 32,
  parameter int unsigned      CBE_W      = 4,
  parameter logic [AD_W-1:0]  PARK_AD    = '0,
  parameter logic [CBE_W-1:0] PARK_CBE   = '0,
  parameter int unsigned      REQ64_HOLD = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_rst_i,
  input  logic             gnt_i,
  input  logic             req_i,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  output logic [AD_W-1:0]  ad_o,
  output logic [CBE_W-1:0] cbe_o,
  output logic             ad_cbe_oe_o,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             req64_o
);
  drv_mode_e mode;

  park_decider u_decide (
    .clk_i, .rst_ni, .bus_rst_i, .gnt_i, .req_i, .frame_ni, .irdy_ni,
    .mode_o (mode)
  );

  bus_drv #(.AD_W(AD_W), .CBE_W(CBE_W), .PARK_AD(PARK_AD), .PARK_CBE(PARK_CBE)) u_drv (
    .mode_i (mode),
    .oe_o   (ad_cbe_oe_o),
    .ad_o   (ad_o),
    .cbe_o  (cbe_o)
  );

  par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_par (
    .clk_i, .rst_ni, .bus_rst_i,
    .oe_i     (ad_cbe_oe_o),
    .ad_i     (ad_o),
    .cbe_i    (cbe_o),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  req64_timer #(.HOLD(REQ64_HOLD)) u_req64 (
    .clk_i, .rst_ni, .bus_rst_i,
    .req64_o (req64_o)
  );

  a_r4_rst_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (ad_cbe_oe_o && ad_o == '0 && cbe_o == '0 && !par_o));
  a_r5_par_trails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_i |=> (par_oe_o == $past(ad_cbe_oe_o) && par_o == ^{$past(ad_o), $past(cbe_o)}));
  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!ad_cbe_oe_o && !req64_o));
endmodule

// File: tb/tb_pci_park_ctrl.sv
module tb_pci_park_ctrl;
  localparam int unsigned AD_W  = 32;
  localparam int unsigned CBE_W = 4;
  localparam logic [AD_W-1:0]  P_AD  = 32'h1234_5A5A;
  localparam logic [CBE_W-1:0] P_CBE = 4'h3;
  localparam int HOLD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bus_rst_i = 1'b0, gnt_i = 1'b0, req_i = 1'b0, frame_ni = 1'b1, irdy_ni = 1'b1;
  logic [AD_W-1:0] ad_o;
  logic [CBE_W-1:0] cbe_o;
  logic ad_cbe_oe_o, par_o, par_oe_o, req64_o;

  int checks = 0, fails = 0, hi_cnt = 0, cyc = 0;
  string req_tag = "R6 R7";

  always #5 clk_i = ~clk_i;

  pci_park_ctrl #(.AD_W(AD_W), .CBE_W(CBE_W), .PARK_AD(P_AD), .PARK_CBE(P_CBE),
                  .REQ64_HOLD(HOLD)) dut (.*);

  // behavioural reference
  bit m_oe, m_zero, m_par, m_paroe, m_req, m_prst;
  int m_age;
  logic [AD_W-1:0] e_ad;
  logic [CBE_W-1:0] e_cbe;

  always_comb begin
    e_ad  = (m_oe && !m_zero) ? P_AD  : '0;
    e_cbe = (m_oe && !m_zero) ? P_CBE : '0;
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_oe = 0; m_zero = 0; m_par = 0; m_paroe = 0; m_req = 0; m_prst = 0; m_age = 0;
    end else begin
      m_par   = bus_rst_i ? 1'b0 : (^{e_ad, e_cbe});
      m_paroe = m_oe;
      m_zero  = bus_rst_i;
      m_oe    = bus_rst_i || (gnt_i && !req_i && frame_ni && irdy_ni);
      if (bus_rst_i && !m_prst) begin
        m_req = 1; m_age = 0;
      end else if (m_req) begin
        m_age++;
        if (!bus_rst_i && m_age >= HOLD) m_req = 0;
      end
      m_prst = bus_rst_i;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (req64_o) hi_cnt++;
    if (rst_ni) begin
      chk("R2 R3 R4 oe",  64'(ad_cbe_oe_o), 64'(m_oe));
      chk("R2 R3 R4 ad",  64'(ad_o),  64'(e_ad));
      chk("R2 R3 R4 cbe", 64'(cbe_o), 64'(e_cbe));
      chk("R4 R5 par",    64'(par_o), 64'(m_par));
      chk("R5 par_oe",    64'(par_oe_o), 64'(m_paroe));
      chk(req_tag,        64'(req64_o), 64'(m_req));
    end
  end

  task automatic pulse(input int n);
    bus_rst_i = 1'b1;
    @(negedge clk_i);
    chk("R6 window open", 64'(req64_o), 64'd1);
    chk("R4 zero drive", 64'({ad_cbe_oe_o, ad_o, cbe_o}), 64'({1'b1, 36'd0}));
    repeat (n - 1) @(negedge clk_i);
    bus_rst_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", 64'({ad_cbe_oe_o, par_oe_o, req64_o, par_o, ad_o, cbe_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", 64'({ad_cbe_oe_o, par_oe_o, req64_o}), 64'd0);
    // R2 park, then R3 each blocking condition
    gnt_i = 1; repeat (3) @(negedge clk_i);
    chk("R2 parked", 64'(ad_o), 64'(P_AD));
    req_i = 1; @(negedge clk_i); req_i = 0; @(negedge clk_i);
    frame_ni = 0; @(negedge clk_i); frame_ni = 1; irdy_ni = 0; @(negedge clk_i);
    irdy_ni = 1; @(negedge clk_i);
    gnt_i = 0; @(negedge clk_i);
    chk("R3 off one clock after grant drop", 64'(ad_cbe_oe_o), 64'd0);
    // R7 short pulse: minimum hold
    hi_cnt = 0; pulse(3); repeat (30) @(negedge clk_i);
    chk("R7 short pulse length", 64'(hi_cnt), 64'(HOLD));
    // R7 long reset: held to reset end
    gnt_i = 1;
    hi_cnt = 0; pulse(15); repeat (30) @(negedge clk_i);
    chk("R7 long reset length", 64'(hi_cnt), 64'd15);
    // R8 re-raise inside window
    req_tag = "R8";
    hi_cnt = 0; pulse(2); repeat (5) @(negedge clk_i); pulse(2);
    repeat (30) @(negedge clk_i);
    chk("R8 restart length", 64'(hi_cnt), 64'(7 + HOLD));
    req_tag = "R6 R7";
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      gnt_i     = ($urandom % 4) != 0;
      req_i     = ($urandom % 3) == 0;
      frame_ni  = ($urandom % 4) != 0;
      irdy_ni   = ($urandom % 4) != 0;
      bus_rst_i = ($urandom % 40) == 0;
      @(negedge clk_i);
    end
    bus_rst_i = 0;
    repeat (20) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule